// File: doc/BRIEF.md
# Semi-universal polygonal switch block

This block is a programmable routing junction with `S = SP + SO + SI` sides and `M` terminals on each side. The sides fall into three groups: a group of pad sides, a group of logic-output sides and a group of logic-input sides. Each programmable switch can tie terminal `j` of one side to the mirrored terminal `M-1-j` of a side in another group. Two sides of the same group are never joined. A terminal that reaches another through several ON switches shares one net with it, however long the chain.

The switch settings are held in a serial configuration chain with one bit per switch. Connectivity is modelled as a logic resolution and not as an electrical one. Every terminal has a drive enable and a drive value. Every terminal reads back the OR of the values driven onto its net. A conflict flag reports a net that has more than one enabled driver. The block is used as the middle stage between connection crossbars. Software programs the chain once, and the terminals then carry the routed signals.

Top module: `swb_polygon`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) turns every switch OFF. With every switch OFF, each terminal reads only its own drive (`drv_en & drv_val`) and `conflict` is low.
- R2: At each rising edge with `rst` low and `cfg_en` high, the stored switch vector moves one place toward the higher index and `cfg_data` enters bit 0. The chain is exactly `M*(SP*SO + SP*SI + SO*SI)` bits long, so after that many shifts the first bit sent controls the highest-numbered switch. A bit shifted past the top of the chain is lost.
- R3: At a rising edge with `rst` low and `cfg_en` low, the stored switch vector keeps its value, whatever `cfg_data` carries.
- R4: Terminals are numbered `side*M + j`, with sides and `j` counted from 0. Sides `0..SP-1` are pads, the next `SO` sides are outputs and the last `SI` sides are inputs. Switches are enumerated over side pairs `i < k` whose sides lie in different groups: `i` ascending, then `k` ascending, then `j` ascending. Switch number `s = pair_rank*M + j` joins terminal `j` of side `i` to terminal `M-1-j` of side `k`. No other pair of terminals is ever joined.
- R5: An ON switch places its two terminals on one net, and nets merge transitively through chains of ON switches. Every terminal of a net reads the OR of `drv_val` over the terminals of that net whose `drv_en` is high.
- R6: A terminal's own enabled drive is always part of what it reads. A net with no enabled driver reads 0. The `drv_val` of a terminal whose `drv_en` is low has no effect on any output.
- R7: `conflict` is high exactly when some net holds two or more terminals with `drv_en` high, whatever values they drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rst | input | 1 | Synchronous reset, active high, turns every switch OFF |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_data | input | 1 | Serial configuration bit, highest switch first |
| drv_en | input | S*M | Per-terminal drive enable |
| drv_val | input | S*M | Per-terminal drive value |
| res_val | output | S*M | Per-terminal resolved net value |
| conflict | output | 1 | Two or more enabled drivers share a net |

## Verification
The assertions check the chain on every cycle: a shift on enable, a hold without it, and a clear after reset. On every cycle they also check that each ON switch gives its two terminals equal readings, that an enabled high drive is seen at its own terminal, and that idle terminals or a single driver never raise a conflict. Only the bench's scenarios can show the parts that depend on the whole configuration. These are the mirrored index pairing, the exact enumeration order of the switches, merging across chains of switches, and the exact conflict condition. The bench checks them against a net-by-net search model, both with directed patterns and with random configurations.

// File: rtl/swb_pkg.sv
package swb_pkg;

    // Group of a side, counted from 0: 0 pads, 1 logic outputs, 2 logic inputs
    function automatic int side_group(input int side, input int sp, input int so);
        if (side < sp) begin
            return 0;
        end
        if (side < sp + so) begin
            return 1;
        end
        return 2;
    endfunction

    function automatic int switch_total(input int m, input int sp, input int so, input int si);
        return m * (sp * so + sp * si + so * si);
    endfunction

    // Terminal index of one end of switch idx (far_end selects the higher side)
    function automatic int switch_end(input int idx, input bit far_end,
                                      input int m, input int sp, input int so, input int si);
        int sides;
        int cnt;
        sides = sp + so + si;
        cnt   = 0;
        for (int i = 0; i < sides; i++) begin
            for (int k = i + 1; k < sides; k++) begin
                if (side_group(i, sp, so) != side_group(k, sp, so)) begin
                    for (int j = 0; j < m; j++) begin
                        if (cnt == idx) begin
                            return far_end ? (k * m + (m - 1 - j)) : (i * m + j);
                        end
                        cnt++;
                    end
                end
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/swb_cfg_chain.sv
module swb_cfg_chain #(
    parameter int NSW = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_en,
    input  logic           cfg_data,
    output logic [NSW-1:0] cfg_q
);

    typedef struct packed {
        logic [NSW-1:0] bits;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.bits = '0;
        end else if (cfg_en) begin
            st_d.bits = {st_q.bits[NSW-2:0], cfg_data};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cfg_q = st_q.bits;

endmodule

// File: rtl/swb_fabric.sv
module swb_fabric
    import swb_pkg::*;
#(
    parameter int M  = 2,
    parameter int SP = 1,
    parameter int SO = 1,
    parameter int SI = 2,
    localparam int N   = (SP + SO + SI) * M,
    localparam int NSW = switch_total(M, SP, SO, SI)
) (
    input  logic [NSW-1:0]        cfg_q,
    output logic [N-1:0][N-1:0]   reach
);

    logic [N-1:0][N-1:0] adj_d;
    logic [N-1:0][N-1:0] clos_d;

    // Direct adjacency from ON switches, each terminal reaching itself
    always_comb begin
        adj_d = '0;
        for (int t = 0; t < N; t++) begin
            adj_d[t][t] = 1'b1;
        end
        for (int s = 0; s < NSW; s++) begin
            if (cfg_q[s]) begin
                adj_d[switch_end(s, 1'b0, M, SP, SO, SI)][switch_end(s, 1'b1, M, SP, SO, SI)] = 1'b1;
                adj_d[switch_end(s, 1'b1, M, SP, SO, SI)][switch_end(s, 1'b0, M, SP, SO, SI)] = 1'b1;
            end
        end
    end

    // Transitive closure, pivot terminal outermost
    always_comb begin
        clos_d = adj_d;
        for (int k = 0; k < N; k++) begin
            for (int a = 0; a < N; a++) begin
                if (clos_d[a][k]) begin
                    clos_d[a] = clos_d[a] | clos_d[k];
                end
            end
        end
    end

    assign reach = clos_d;

endmodule

// File: rtl/swb_resolve.sv
module swb_resolve #(
    parameter int N = 8
) (
    input  logic [N-1:0][N-1:0] reach,
    input  logic [N-1:0]        drv_en,
    input  logic [N-1:0]        drv_val,
    output logic [N-1:0]        res_val,
    output logic                conflict
);

    logic [N-1:0] src_d;
    logic [N-1:0] res_d;
    logic         clash_d;

    always_comb begin
        src_d   = drv_en & drv_val;
        res_d   = '0;
        clash_d = 1'b0;
        for (int t = 0; t < N; t++) begin
            res_d[t] = |(reach[t] & src_d);
            if ($countones(reach[t] & drv_en) > 1) begin
                clash_d = 1'b1;
            end
        end
    end

    assign res_val  = res_d;
    assign conflict = clash_d;

endmodule

// File: rtl/swb_polygon.sv
module swb_polygon
    import swb_pkg::*;
#(
    parameter int M  = 2,
    parameter int SP = 1,
    parameter int SO = 1,
    parameter int SI = 2,
    localparam int S   = SP + SO + SI,
    localparam int N   = S * M,
    localparam int NSW = switch_total(M, SP, SO, SI)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_en,
    input  logic         cfg_data,
    input  logic [N-1:0] drv_en,
    input  logic [N-1:0] drv_val,
    output logic [N-1:0] res_val,
    output logic         conflict
);

    generate
        if ((M % 2) != 0 || M < 2 || SP < 1 || SO < 1 || SI < 1) begin : g_bad_param
            $error("swb_polygon: M must be even and every group needs one side");
        end
    endgenerate

    logic [NSW-1:0]      cfg_q;
    logic [N-1:0][N-1:0] reach;

    swb_cfg_chain #(.NSW(NSW)) i_chain (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_data (cfg_data),
        .cfg_q    (cfg_q)
    );

    swb_fabric #(.M(M), .SP(SP), .SO(SO), .SI(SI)) i_fabric (
        .cfg_q (cfg_q),
        .reach (reach)
    );

    swb_resolve #(.N(N)) i_resolve (
        .reach    (reach),
        .drv_en   (drv_en),
        .drv_val  (drv_val),
        .res_val  (res_val),
        .conflict (conflict)
    );

endmodule

// File: rtl/swb_polygon_chk.sv
module swb_polygon_chk
    import swb_pkg::*;
#(
    parameter int M  = 2,
    parameter int SP = 1,
    parameter int SO = 1,
    parameter int SI = 2,
    localparam int N   = (SP + SO + SI) * M,
    localparam int NSW = switch_total(M, SP, SO, SI)
) (
    input logic           clk,
    input logic           rst,
    input logic           cfg_en,
    input logic           cfg_data,
    input logic [NSW-1:0] cfg,
    input logic [N-1:0]   drv_en,
    input logic [N-1:0]   drv_val,
    input logic [N-1:0]   res_val,
    input logic           conflict
);

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (cfg == '0)); // R1

    AST_ALL_OPEN: assert property (@(posedge clk) disable iff (rst)
        (cfg == '0) |-> (res_val == (drv_en & drv_val)) && !conflict); // R1

    AST_CFG_SHIFT: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (cfg[0] == $past(cfg_data)) && (cfg[NSW-1:1] == $past(cfg[NSW-2:0]))); // R2

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (drv_en == '0) |-> (res_val == '0) && !conflict); // R6

    AST_LONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
        ($countones(drv_en) <= 1) |-> !conflict); // R7

    generate
        for (genvar t = 0; t < N; t++) begin : g_term
            AST_OWN_DRIVE: assert property (@(posedge clk) disable iff (rst)
                (drv_en[t] && drv_val[t]) |-> res_val[t]); // R6
        end
        for (genvar s = 0; s < NSW; s++) begin : g_sw
            localparam int EA = switch_end(s, 1'b0, M, SP, SO, SI);
            localparam int EB = switch_end(s, 1'b1, M, SP, SO, SI);
            AST_PAIR_SHARE: assert property (@(posedge clk) disable iff (rst)
                cfg[s] |-> (res_val[EA] == res_val[EB])); // R5
        end
    endgenerate

endmodule

bind swb_polygon swb_polygon_chk #(.M(M), .SP(SP), .SO(SO), .SI(SI)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_data (cfg_data),
    .cfg      (cfg_q),
    .drv_en   (drv_en),
    .drv_val  (drv_val),
    .res_val  (res_val),
    .conflict (conflict)
);

// File: tb/test_swb_polygon.sv
module test_swb_polygon;

    localparam int M   = 2;
    localparam int SP  = 1;
    localparam int SO  = 1;
    localparam int SI  = 2;
    localparam int S   = SP + SO + SI;
    localparam int N   = S * M;
    localparam int NSW = M * (SP * SO + SP * SI + SO * SI);

    logic         clk = 1'b0;
    logic         rst;
    logic         cfg_en;
    logic         cfg_data;
    logic [N-1:0] drv_en;
    logic [N-1:0] drv_val;
    logic [N-1:0] res_val;
    logic         conflict;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 0;
    string cur_tag  = "R1";

    bit ref_cfg [NSW];
    int ep_a [NSW];
    int ep_b [NSW];

    always #5 clk = ~clk;

    swb_polygon #(.M(M), .SP(SP), .SO(SO), .SI(SI)) i_swb_polygon (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_data (cfg_data),
        .drv_en   (drv_en),
        .drv_val  (drv_val),
        .res_val  (res_val),
        .conflict (conflict)
    );

    function automatic int grp_of(input int side);
        if (side < SP) return 0;
        if (side < SP + SO) return 1;
        return 2;
    endfunction

    // Switch endpoints written out from the enumeration rule of R4
    task automatic build_list();
        int idx = 0;
        for (int i = 0; i < S; i++)
            for (int k = i + 1; k < S; k++)
                if (grp_of(i) != grp_of(k))
                    for (int j = 0; j < M; j++) begin
                        ep_a[idx] = i * M + j;
                        ep_b[idx] = k * M + (M - 1 - j);
                        idx++;
                    end
    endtask

    // Search each terminal's net and resolve it
    task automatic model(output logic [N-1:0] exp_res, output logic exp_clash);
        exp_res   = '0;
        exp_clash = 1'b0;
        for (int t = 0; t < N; t++) begin
            bit seen [N];
            int q [$];
            int drivers = 0;
            for (int u = 0; u < N; u++) seen[u] = 0;
            q.push_back(t);
            seen[t] = 1;
            while (q.size() > 0) begin
                int u = q.pop_front();
                if (drv_en[u]) begin
                    drivers++;
                    if (drv_val[u]) exp_res[t] = 1'b1;
                end
                for (int s = 0; s < NSW; s++) begin
                    if (ref_cfg[s] && ep_a[s] == u && !seen[ep_b[s]]) begin
                        seen[ep_b[s]] = 1; q.push_back(ep_b[s]);
                    end
                    if (ref_cfg[s] && ep_b[s] == u && !seen[ep_a[s]]) begin
                        seen[ep_a[s]] = 1; q.push_back(ep_a[s]);
                    end
                end
            end
            if (drivers > 1) exp_clash = 1'b1;
        end
    endtask

    task automatic check_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: res_val actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: conflict actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, compare with the model 2 ns later
    task automatic apply(input logic en, input logic d, input logic r);
        logic [N-1:0] er;
        logic         ec;
        cfg_en   = en;
        cfg_data = d;
        rst      = r;
        #2;
        model(er, ec);
        check_vec({cur_tag, " model"}, res_val, er);
        check_bit({cur_tag, " model"}, conflict, ec);
    endtask

    task automatic step();
        @(posedge clk);
        if (rst) begin
            for (int s = 0; s < NSW; s++) ref_cfg[s] = 0;
        end else if (cfg_en) begin
            for (int s = NSW - 1; s > 0; s--) ref_cfg[s] = ref_cfg[s-1];
            ref_cfg[0] = cfg_data;
        end
        @(negedge clk);
    endtask

    task automatic load(input logic [NSW-1:0] pat);
        for (int b = NSW - 1; b >= 0; b--) begin
            apply(1'b1, pat[b], 1'b0);
            step();
        end
        apply(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        build_list();
        for (int s = 0; s < NSW; s++) ref_cfg[s] = 0;
        rst = 1'b1; cfg_en = 1'b0; cfg_data = 1'b0;
        drv_en = '0; drv_val = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);

        // R1: reset state, every terminal isolated
        cur_tag = "R1";
        drv_en = '1; drv_val = 8'b1010_0110;
        apply(1'b0, 1'b0, 1'b0);
        check_vec("R1 isolated", res_val, 8'b1010_0110);
        check_bit("R1 isolated", conflict, 1'b0);
        step();

        // R2/R4: only switch 0 (terminal 0 with terminal 3)
        cur_tag = "R2";
        drv_en = '0; drv_val = '0;
        load(10'b00_0000_0001);
        drv_en = 8'b0000_0001; drv_val = 8'b0000_0001;
        apply(1'b0, 1'b0, 1'b0);
        check_vec("R2 switch0", res_val, 8'b0000_1001);
        step();

        // R4: mirrored pairing, switch 1 joins terminal 1 with terminal 2
        cur_tag = "R4";
        load(10'b00_0000_0010);
        drv_en = 8'b0000_0010; drv_val = 8'b0000_0010;
        apply(1'b0, 1'b0, 1'b0);
        check_vec("R4 mirror", res_val, 8'b0000_0110);
        step();

        // R2: highest switch 9 joins terminal 3 with terminal 6
        cur_tag = "R2";
        load(10'b10_0000_0000);
        drv_en = 8'b0000_1000; drv_val = 8'b0000_1000;
        apply(1'b0, 1'b0, 1'b0);
        check_vec("R2 switch9", res_val, 8'b0100_1000);
        step();

        // R3: chain holds while cfg_data toggles with cfg_en low
        cur_tag = "R3";
        for (int c = 0; c < 6; c++) begin
            apply(1'b0, c[0], 1'b0);
            step();
        end
        apply(1'b0, 1'b0, 1'b0);
        check_vec("R3 hold", res_val, 8'b0100_1000);
        step();

        // R5: chain through switches 0 and 7 (0-3, 3-4)
        cur_tag = "R5";
        load(10'b00_1000_0001);
        drv_en = 8'b0000_0001; drv_val = 8'b0000_0001;
        apply(1'b0, 1'b0, 1'b0);
        check_vec("R5 chain", res_val, 8'b0001_1001);
        check_bit("R5 chain", conflict, 1'b0);
        step();

        // R7: second driver on the net, driving 0
        cur_tag = "R7";
        drv_en = 8'b0001_0001; drv_val = 8'b0000_0001;
        apply(1'b0, 1'b0, 1'b0);
        check_vec("R7 clash", res_val, 8'b0001_1001);
        check_bit("R7 clash", conflict, 1'b1);
        step();
        drv_val = '0;
        apply(1'b0, 1'b0, 1'b0);
        check_vec("R7 low clash", res_val, 8'b0000_0000);
        check_bit("R7 low clash", conflict, 1'b1);
        step();

        // R6: a disabled driver's value is ignored
        cur_tag = "R6";
        drv_en = 8'b0000_0000; drv_val = 8'b1111_1111;
        apply(1'b0, 1'b0, 1'b0);
        check_vec("R6 disabled", res_val, 8'b0000_0000);
        check_bit("R6 disabled", conflict, 1'b0);
        step();

        // R2: one extra shift pushes the top bit out of the chain
        cur_tag = "R2";
        load(10'b00_0000_0000);
        apply(1'b1, 1'b1, 1'b0);
        step();
        for (int b = 0; b < NSW; b++) begin
            apply(1'b1, 1'b0, 1'b0);
            step();
        end
        drv_en = 8'b0000_1001; drv_val = 8'b0000_1001;
        apply(1'b0, 1'b0, 1'b0);
        check_vec("R2 length", res_val, 8'b0000_1001);
        check_bit("R2 length", conflict, 1'b0);
        step();

        // R1: reset after a full configuration
        load('1);
        cur_tag = "R1";
        apply(1'b0, 1'b0, 1'b1);
        step();
        drv_en = '1; drv_val = 8'b0011_1100;
        apply(1'b0, 1'b0, 1'b0);
        check_vec("R1 re-reset", res_val, 8'b0011_1100);
        check_bit("R1 re-reset", conflict, 1'b0);
        step();

        // R5/R7: random configurations and drives against the model
        cur_tag = "R5 R7 random";
        for (int r = 0; r < 60; r++) begin
            load(NSW'($urandom));
            for (int p = 0; p < 4; p++) begin
                drv_en  = N'($urandom) & N'($urandom);
                drv_val = N'($urandom);
                apply(1'b0, 1'b0, 1'b0);
                step();
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule